// File: doc/BRIEF.md
# Strobe Watchdog Timer with Selectable Timeout

This block watches a strobe line driven by a processor and asks for a system reset when the processor stops toggling it. Each high-to-low transition of the strobe restarts a millisecond count. If the count reaches the selected period before another falling edge arrives, the block emits a one-clock expiry pulse. The reset generator uses that pulse to start a reset of its full hold time.

The strobe is asynchronous. It passes through a synchronizer, and falling edges are detected at the full clock rate rather than at the millisecond rate. A short low pulse is therefore caught even when it falls between two millisecond ticks. A 2-bit select picks one of three periods. While the system reset is active, the count is held at zero, so timing begins only once the reset is released. The decoding of a three-level analog pin into the 2-bit select happens outside this block.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst` is high, `expire_o` is 0 and the count is cleared. The first expiry after `rst` falls comes exactly one full period of ticks later.
- R2: `period_sel` codes map to periods in ticks: 2'b00 gives 150, 2'b01 gives 600, 2'b10 gives 1200, and the spare code 2'b11 gives 600.
- R3: `expire_o` is high for exactly one clock cycle. It rises on the clock edge that samples the period-th `tick_ms` pulse since the last restart, and the count then starts again from zero.
- R4: Only a high-to-low transition of `strobe_n`, after synchronization, restarts the count. A rising edge or a steady level of either polarity leaves the count running.
- R5: A low pulse on `strobe_n` that lasts 2 clock cycles is recognized as a restart, wherever it falls between ticks.
- R6: While `hold_reset` is high, the count is held at zero and `expire_o` stays 0. Counting resumes with the first tick sampled after `hold_reset` falls.
- R7: If `period_sel` changes to a shorter period while the count already meets or exceeds the new limit, `expire_o` fires on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-clock pulse once per millisecond |
| strobe_n | input | 1 | Asynchronous strobe from the processor; falling edges restart timing |
| period_sel | input | 2 | Timeout period select (00: 150, 01: 600, 10: 1200, 11: 600 ticks) |
| hold_reset | input | 1 | High while the system reset is asserted; holds the count cleared |
| expire_o | output | 1 | One-cycle timeout pulse to the reset generator |

## Verification
The bench targets the exact expiry tick for every select code, including the spare code. A period that is off by one tick, or a decode that is swapped, would move or drop the pulse. It holds the strobe low across many ticks and then raises it, to catch a design that restarts on rising edges or on a static level: such a design would delay the expiry. It also sends a 2-cycle low pulse in the middle of a tick gap and shortens the select mid-count; a design that samples at the tick rate or compares only for equality would miss the first or fail to fire on the second. Random sequences of kicks, holds and select changes are checked cycle by cycle against a bench model of the count.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_SPARE = 2'b11
  } period_sel_e;
endpackage

// File: rtl/swd_strobe_sync.sv
// Synchronizes the asynchronous strobe and flags falling edges at clock rate.
module swd_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic fall_o
);
  // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] holds previous value
  logic [SYNC_STAGES:0] chain;
  logic                 fall_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= strobe_async;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b1;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
  end

  assign fall_o = fall_q;

  // R4: a single falling edge yields a single restart pulse
  a_r4_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_q |=> !fall_q);
endmodule

// File: rtl/swd_period_sel.sv
// Registers the timeout limit chosen by the 2-bit select.
module swd_period_sel
  import swd_pkg::*;
#(
  parameter int SHORT_MS = 150,
  parameter int MID_MS   = 600,
  parameter int LONG_MS  = 1200,
  parameter int CNT_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_in,
  output logic [CNT_W-1:0] limit_o
);
  logic [CNT_W-1:0] limit_d;
  logic [CNT_W-1:0] limit_q;

  always_comb begin
    case (period_sel_e'(sel_in))
      SEL_SHORT: limit_d = CNT_W'(SHORT_MS);
      SEL_LONG:  limit_d = CNT_W'(LONG_MS);
      default:   limit_d = CNT_W'(MID_MS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) limit_q <= CNT_W'(MID_MS);
    else     limit_q <= limit_d;
  end

  assign limit_o = limit_q;

  // R2: the registered limit is always one of the three presets
  a_r2_limit_legal: assert property (@(posedge clk) disable iff (rst)
    (limit_q == CNT_W'(SHORT_MS)) || (limit_q == CNT_W'(MID_MS)) ||
    (limit_q == CNT_W'(LONG_MS)));
endmodule

// File: rtl/swd_tick_counter.sv
// Counts millisecond ticks since the last restart and pulses on expiry.
module swd_tick_counter #(
  parameter int CNT_W     = 11,
  parameter int MAX_LIMIT = 1200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt;
  logic             expire_q;
  logic             at_limit;

  assign at_limit = (cnt >= (limit - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt      <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (restart) begin
        cnt <= '0;
      end else if (tick) begin
        if (at_limit) begin
          cnt      <= '0;
          expire_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign expire_o = expire_q;

  // R3: expiry pulse lasts a single clock
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    expire_q |=> !expire_q);
  // R6: hold keeps the count cleared and blocks expiry
  a_r6_hold_clears: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0) && !expire_q);
  // R4: a restart clears the count
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
    (restart && !hold) |=> (cnt == '0));
  // R3: without a tick the count does not move and nothing expires
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart && !hold) |=> $stable(cnt) && !expire_q);
  // R2: the count stays below the longest period
  a_r2_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_LIMIT));
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int SHORT_MS    = 150,
  parameter int MID_MS      = 600,
  parameter int LONG_MS     = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms,
  input  logic       strobe_n,
  input  logic [1:0] period_sel,
  input  logic       hold_reset,
  output logic       expire_o
);
  localparam int CNT_W = $clog2(LONG_MS + 1);

  logic             fall;
  logic [CNT_W-1:0] limit;

  swd_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_async(strobe_n), .fall_o(fall)
  );

  swd_period_sel #(
    .SHORT_MS(SHORT_MS), .MID_MS(MID_MS), .LONG_MS(LONG_MS), .CNT_W(CNT_W)
  ) u_period (
    .clk(clk), .rst(rst), .sel_in(period_sel), .limit_o(limit)
  );

  swd_tick_counter #(.CNT_W(CNT_W), .MAX_LIMIT(LONG_MS)) u_count (
    .clk(clk), .rst(rst), .hold(hold_reset), .tick(tick_ms),
    .restart(fall), .limit(limit), .expire_o(expire_o)
  );

  // R1: no expiry while in reset
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !expire_o);
endmodule

// File: tb/strobe_watchdog_bench.sv
`timescale 1ns/1ps
module strobe_watchdog_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b0;
  logic       strobe_n = 1'b1;
  logic [1:0] period_sel = 2'b00;
  logic       hold_reset = 1'b0;
  logic       expire_o;

  int    checks = 0;
  int    failures = 0;
  int    pulses = 0;
  int    kick_id = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  strobe_watchdog u_strobe_watchdog (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .strobe_n(strobe_n),
    .period_sel(period_sel), .hold_reset(hold_reset), .expire_o(expire_o)
  );

  always #2.5 clk = ~clk;

  function automatic int period_of(logic [1:0] s);
    case (s)
      2'b00:   return 150;
      2'b10:   return 1200;
      default: return 600;
    endcase
  endfunction

  // tick every 10 clocks
  initial begin
    forever begin
      repeat (9) @(negedge clk);
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
    end
  end

  // cycle-level reference model and output check
  int model_cnt = 0;
  int kick_seen = 0;
  bit exp_e;
  always @(posedge clk) begin
    #1;
    exp_e = 1'b0;
    if (kick_seen != kick_id) begin
      kick_seen = kick_id;
      model_cnt = 0;
    end
    if (rst || hold_reset) begin
      model_cnt = 0;
    end else if (tick_ms) begin
      if (model_cnt + 1 >= period_of(period_sel)) begin
        model_cnt = 0;
        exp_e = 1'b1;
      end else begin
        model_cnt = model_cnt + 1;
      end
    end
    if (expire_o) pulses = pulses + 1;
    if (!done) begin
      checks = checks + 1;
      if (expire_o !== exp_e) begin
        failures = failures + 1;
        $display("FAIL %s expire_o actual=%0b expected=%0b at %0t",
                 cur_tag, expire_o, exp_e, $time);
      end
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk iff tick_ms);
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic check_pulses(input string tag, input int expected);
    checks = checks + 1;
    if (pulses != expected) begin
      failures = failures + 1;
      $display("FAIL %s pulse count actual=%0d expected=%0d", tag, pulses, expected);
    end
  endtask

  // low for two clocks, then back high
  task automatic kick();
    strobe_n = 1'b0;
    kick_id = kick_id + 1;
    repeat (2) @(negedge clk);
    strobe_n = 1'b1;
  endtask

  task automatic period_run(input string tag, input logic [1:0] s);
    int p0;
    int len;
    cur_tag = tag;
    period_sel = s;
    len = period_of(s);
    wait_ticks(1);
    kick();
    wait_ticks(1);
    p0 = pulses;
    // one tick already elapsed since the kick
    wait_ticks(len - 2);
    check_pulses(tag, p0);
    wait_ticks(1);
    check_pulses(tag, p0 + 1);
    wait_ticks(len);
    check_pulses({tag, " restart R3"}, p0 + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p0;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    // R1: quiet during reset
    repeat (6) @(negedge clk);
    checks = checks + 1;
    if (expire_o !== 1'b0) begin
      failures = failures + 1;
      $display("FAIL R1 expire_o in reset actual=%0b expected=0", expire_o);
    end
    rst = 1'b0;
    p0 = pulses;
    wait_ticks(149);
    check_pulses("R1", p0);
    wait_ticks(1);
    check_pulses("R1", p0 + 1);

    // R2 / R3: every select code
    period_run("R2 sel00", 2'b00);
    period_run("R2 sel01", 2'b01);
    period_run("R2 sel10", 2'b10);
    period_run("R2 sel11", 2'b11);

    // R4: rising edge and static low do not restart
    cur_tag = "R4";
    period_sel = 2'b00;
    wait_ticks(1);
    strobe_n = 1'b0;
    kick_id = kick_id + 1;
    p0 = pulses;
    wait_ticks(100);
    strobe_n = 1'b1;
    wait_ticks(49);
    check_pulses("R4 rise ignored", p0);
    wait_ticks(1);
    check_pulses("R4 rise ignored", p0 + 1);
    // R4: periodic falls prevent expiry
    kick();
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      wait_ticks(100);
      kick();
    end
    check_pulses("R4 periodic", p0);

    // R5: short pulse restarts, fired late in a tick gap
    cur_tag = "R5";
    p0 = pulses;
    for (int i = 0; i < 3; i++) begin
      wait_ticks(120);
      repeat (2) @(negedge clk);
      kick();
    end
    check_pulses("R5", p0);

    // R6: hold keeps the count at zero
    cur_tag = "R6";
    hold_reset = 1'b1;
    p0 = pulses;
    wait_ticks(300);
    check_pulses("R6 held", p0);
    hold_reset = 1'b0;
    wait_ticks(149);
    check_pulses("R6 resume", p0);
    wait_ticks(1);
    check_pulses("R6 resume", p0 + 1);

    // R7: shortening the period past the count fires on next tick
    cur_tag = "R7";
    period_sel = 2'b01;
    wait_ticks(1);
    kick();
    wait_ticks(300);
    p0 = pulses;
    period_sel = 2'b00;
    wait_ticks(1);
    check_pulses("R7", p0 + 1);

    // random mix, model-checked every cycle
    for (int i = 0; i < 15; i++) begin
      int act;
      act = int'($urandom_range(0, 3));
      cur_tag = "R3 random";
      period_sel = 2'($urandom_range(0, 3));
      case (act)
        0: kick();
        1: begin
          cur_tag = "R6 random";
          hold_reset = 1'b1;
          wait_ticks(int'($urandom_range(1, 40)));
          hold_reset = 1'b0;
        end
        default: ;
      endcase
      wait_ticks(int'($urandom_range(1, 200)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule